// File: doc/BRIEF.md
# CRC-4 Multiframe Alignment Controller

This block decides when an E1 receiver has found CRC-4 multiframe alignment. It works on top of an existing basic frame aligner. It receives a one-cycle strobe for every 125 µs frame and a level that is high while basic (doubleframe) alignment holds. It also receives a pulse whenever the multiframe pattern is seen at a frame boundary. From these it produces:

- a multiframe-lost flag and a one-cycle regain interrupt;
- a CRC-check enable;
- a window-timeout interrupt;
- a request asking the basic aligner to search again;
- a request to force AIS toward the backplane.

All timing is counted in frame strobes. One multiframe spans 16 frames. When basic alignment is gained, a 64-frame (8 ms) window opens. The first pattern hit re-arms the window with 48 frames (6 ms). A second hit whose distance from the first is a whole number of multiframes declares multiframe alignment. A hit at any other distance becomes the new first hit. If the window runs out, an interrupt is raised and hunting begins again. When automatic resynchronisation is enabled, the same event also asks the basic aligner for a new search.

Top module: `crc4_mf_align`

## Requirements
- R1: After reset, `mf_lost` is 1, `crc_check_en`, `window_irq`, `resync_req` and `mf_regain_irq` are 0, and `ais_req` equals `ais_en`.
- R2: `crc_check_en` goes to 1 in the clock after the first pattern hit (a `mf_pat_hit` together with `frame_tick`) while `df_sync` is 1. It stays at 1 until a window expires without a confirming hit, or until `df_sync` falls.
- R3: A second hit that comes 16·n frame strobes after the first (n = 1, 2 or 3) clears `mf_lost` in the next clock. This includes a hit on the 48th strobe, the last strobe of the window. The flag then stays 0 while `df_sync` stays 1.
- R4: A hit whose distance from the first hit is not a multiple of 16 strobes does not declare alignment. Instead it becomes the new first hit, and it re-arms the 48-strobe window.
- R5: `mf_regain_irq` is a one-clock pulse that occurs exactly in the clock where `mf_lost` falls.
- R6: In the clock after `df_sync` is sampled high, a 64-strobe window starts. If no hit occurs, `window_irq` pulses for one clock after the 64th strobe, and this repeats every 64 strobes.
- R7: After a first hit, if no confirming hit arrives within 48 strobes, `window_irq` pulses and `crc_check_en` returns to 0. Hunting then restarts with a fresh 64-strobe window.
- R8: `resync_req` pulses in the same clock as `window_irq` when `auto_resync_en` was 1 at the expiring strobe. It stays 0 when `auto_resync_en` is 0.
- R9: `ais_req` equals `ais_en` while the block is in its doubleframe-lost state, and is 0 otherwise.
- R10: When `df_sync` is sampled low, the next clock shows `mf_lost`=1 and `crc_check_en`=0, and all window timing is cleared. While aligned, further hits have no effect.
- R11: A `mf_pat_hit` without `frame_tick` in the same clock is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_tick | input | 1 | One-clock strobe per 125 µs frame |
| mf_pat_hit | input | 1 | Multiframe pattern seen at this frame boundary (qualified by frame_tick) |
| df_sync | input | 1 | Basic doubleframe alignment present |
| auto_resync_en | input | 1 | Allow a window timeout to request a new basic search |
| ais_en | input | 1 | Allow AIS insertion while doubleframe alignment is lost |
| mf_lost | output | 1 | Multiframe alignment not established |
| mf_regain_irq | output | 1 | One-clock pulse when multiframe alignment is regained |
| window_irq | output | 1 | One-clock pulse when the search window expires |
| crc_check_en | output | 1 | CRC-4 checking may run (a first pattern has been seen) |
| resync_req | output | 1 | One-clock request for a new doubleframe search |
| ais_req | output | 1 | Request to send AIS toward the backplane |

## Verification
The bench tries three kinds of hit sequence:
- Hit pairs spaced 16 and 48 strobes apart, which must both align. These separate correct spacing arithmetic from an off-by-one at the window edge.
- A misaligned second hit followed by a correctly spaced third. This tells a re-anchoring design apart from one that keeps the stale first hit or accepts any second hit.
- Long stretches without hits, run with automatic resynchronisation off and on. These expose the 64-strobe period, its repetition, and the gating of the resync request.

Hits raised without a frame strobe, hits sent while aligned, and drops of basic alignment show whether unqualified events leak into the state.

// File: rtl/crc4_mf_align_pkg.sv
package crc4_mf_align_pkg;

  typedef enum logic [1:0] {
    ST_DF_LOST  = 2'd0,
    ST_HUNT     = 2'd1,
    ST_CONFIRM  = 2'd2,
    ST_ALIGNED  = 2'd3
  } mfa_state_t;

  // Next value of a modulo-period phase counter.
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned period);
    return (v + 1 >= period) ? 0 : v + 1;
  endfunction

  // True when the next tick lands on a whole multiframe boundary.
  function automatic logic on_boundary(int unsigned v, int unsigned period);
    return wrap_inc(v, period) == 0;
  endfunction

endpackage

// File: rtl/crc4_mf_win_timer.sv
module crc4_mf_win_timer #(
  parameter int unsigned WIN_FRAMES   = 64,
  parameter int unsigned REWIN_FRAMES = 48,
  localparam int unsigned TMR_W = $clog2(WIN_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_full_i,
  input  logic             load_short_i,
  input  logic             tick_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             last_o
);

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (load_full_i) begin
      cnt_q <= TMR_W'(WIN_FRAMES);
    end else if (load_short_i) begin
      cnt_q <= TMR_W'(REWIN_FRAMES);
    end else if (tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == TMR_W'(1));

endmodule

// File: rtl/crc4_mf_spacing.sv
module crc4_mf_spacing
  import crc4_mf_align_pkg::*;
#(
  parameter int unsigned FRAMES_PER_MF = 16,
  localparam int unsigned PH_W = $clog2(FRAMES_PER_MF)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic anchor_i,
  input  logic tick_i,
  output logic aligned_o
);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (anchor_i) begin
      phase_q <= '0;
    end else if (tick_i) begin
      phase_q <= PH_W'(wrap_inc(32'(phase_q), FRAMES_PER_MF));
    end
  end

  // The tick under evaluation completes a whole number of multiframes.
  assign aligned_o = on_boundary(32'(phase_q), FRAMES_PER_MF);

endmodule

// File: rtl/crc4_mf_seq_fsm.sv
module crc4_mf_seq_fsm
  import crc4_mf_align_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_tick,
  input  logic       mf_pat_hit,
  input  logic       df_sync,
  input  logic       auto_resync_en,
  input  logic       timer_last,
  input  logic       spacing_ok,
  output mfa_state_t state_o,
  output logic       tmr_clr,
  output logic       tmr_full,
  output logic       tmr_short,
  output logic       tmr_tick,
  output logic       sp_anchor,
  output logic       sp_tick,
  output logic       evt_expire,
  output logic       evt_good_pair,
  output logic       win_irq_o,
  output logic       resync_o,
  output logic       regain_o
);

  mfa_state_t state_q, state_d;
  logic       hit;
  logic       win_q, resync_q, regain_q;

  assign hit = frame_tick & mf_pat_hit;

  always_comb begin
    state_d       = state_q;
    tmr_clr       = 1'b0;
    tmr_full      = 1'b0;
    tmr_short     = 1'b0;
    tmr_tick      = 1'b0;
    sp_anchor     = 1'b0;
    sp_tick       = 1'b0;
    evt_expire    = 1'b0;
    evt_good_pair = 1'b0;
    if (!df_sync) begin
      state_d = ST_DF_LOST;
      tmr_clr = 1'b1;
    end else begin
      unique case (state_q)
        ST_DF_LOST: begin
          state_d  = ST_HUNT;
          tmr_full = 1'b1;
        end
        ST_HUNT: begin
          if (frame_tick) begin
            if (hit) begin
              state_d   = ST_CONFIRM;
              tmr_short = 1'b1;
              sp_anchor = 1'b1;
            end else if (timer_last) begin
              evt_expire = 1'b1;
              tmr_full   = 1'b1;
            end else begin
              tmr_tick = 1'b1;
            end
          end
        end
        ST_CONFIRM: begin
          if (frame_tick) begin
            sp_tick = 1'b1;
            if (hit && spacing_ok) begin
              state_d       = ST_ALIGNED;
              evt_good_pair = 1'b1;
              tmr_clr       = 1'b1;
            end else if (hit) begin
              sp_anchor = 1'b1;
              tmr_short = 1'b1;
            end else if (timer_last) begin
              evt_expire = 1'b1;
              state_d    = ST_HUNT;
              tmr_full   = 1'b1;
            end else begin
              tmr_tick = 1'b1;
            end
          end
        end
        default: begin
          tmr_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_DF_LOST;
      win_q    <= 1'b0;
      resync_q <= 1'b0;
      regain_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      win_q    <= evt_expire;
      resync_q <= evt_expire & auto_resync_en;
      regain_q <= evt_good_pair;
    end
  end

  assign state_o   = state_q;
  assign win_irq_o = win_q;
  assign resync_o  = resync_q;
  assign regain_o  = regain_q;

endmodule

// File: rtl/crc4_mf_align.sv
module crc4_mf_align
  import crc4_mf_align_pkg::*;
#(
  parameter int unsigned FRAMES_PER_MF = 16,
  parameter int unsigned WIN_FRAMES    = 64,
  parameter int unsigned REWIN_FRAMES  = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic mf_pat_hit,
  input  logic df_sync,
  input  logic auto_resync_en,
  input  logic ais_en,
  output logic mf_lost,
  output logic mf_regain_irq,
  output logic window_irq,
  output logic crc_check_en,
  output logic resync_req,
  output logic ais_req
);

  localparam int unsigned TMR_W = $clog2(WIN_FRAMES + 1);

  mfa_state_t       state;
  logic             tmr_clr, tmr_full, tmr_short, tmr_tick, tmr_last;
  logic             sp_anchor, sp_tick, sp_ok;
  logic             evt_expire, evt_good_pair;
  logic [TMR_W-1:0] timer_cnt;

  crc4_mf_win_timer #(
    .WIN_FRAMES  (WIN_FRAMES),
    .REWIN_FRAMES(REWIN_FRAMES)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (tmr_clr),
    .load_full_i (tmr_full),
    .load_short_i(tmr_short),
    .tick_i      (tmr_tick),
    .cnt_o       (timer_cnt),
    .last_o      (tmr_last)
  );

  crc4_mf_spacing #(
    .FRAMES_PER_MF(FRAMES_PER_MF)
  ) u_spacing (
    .clk      (clk),
    .rst_n    (rst_n),
    .anchor_i (sp_anchor),
    .tick_i   (sp_tick),
    .aligned_o(sp_ok)
  );

  crc4_mf_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_tick    (frame_tick),
    .mf_pat_hit    (mf_pat_hit),
    .df_sync       (df_sync),
    .auto_resync_en(auto_resync_en),
    .timer_last    (tmr_last),
    .spacing_ok    (sp_ok),
    .state_o       (state),
    .tmr_clr       (tmr_clr),
    .tmr_full      (tmr_full),
    .tmr_short     (tmr_short),
    .tmr_tick      (tmr_tick),
    .sp_anchor     (sp_anchor),
    .sp_tick       (sp_tick),
    .evt_expire    (evt_expire),
    .evt_good_pair (evt_good_pair),
    .win_irq_o     (window_irq),
    .resync_o      (resync_req),
    .regain_o      (mf_regain_irq)
  );

  assign mf_lost      = (state != ST_ALIGNED);
  assign crc_check_en = (state == ST_CONFIRM) || (state == ST_ALIGNED);
  assign ais_req      = ais_en && (state == ST_DF_LOST);

endmodule

// File: rtl/crc4_mf_align_chk.sv
module crc4_mf_align_chk #(
  parameter int unsigned WIN_FRAMES = 64,
  parameter int unsigned TMR_W      = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             df_sync,
  input logic             auto_resync_en,
  input logic             mf_lost,
  input logic             mf_regain_irq,
  input logic             window_irq,
  input logic             resync_req,
  input logic             crc_check_en,
  input logic             ais_req,
  input logic             evt_expire,
  input logic             evt_good_pair,
  input logic [TMR_W-1:0] timer_cnt
);

  AST_REGAIN_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    mf_regain_irq |-> $fell(mf_lost)); // R5

  AST_FALL_HAS_REGAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mf_lost) |-> mf_regain_irq); // R5

  AST_PAIR_TO_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    evt_good_pair |=> !mf_lost); // R3

  AST_ALIGNED_CHECKS_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_lost |-> crc_check_en); // R2

  AST_EXPIRE_TO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    evt_expire |=> window_irq); // R6

  AST_WIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    window_irq |=> !window_irq); // R6

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    timer_cnt <= TMR_W'(WIN_FRAMES)); // R6

  AST_RESYNC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |-> (window_irq && $past(auto_resync_en))); // R8

  AST_AIS_ONLY_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    ais_req |-> (mf_lost && !crc_check_en)); // R9

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(df_sync) |=> (mf_lost && !crc_check_en && timer_cnt == '0)); // R10

endmodule

bind crc4_mf_align crc4_mf_align_chk #(
  .WIN_FRAMES(WIN_FRAMES),
  .TMR_W     (TMR_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .df_sync       (df_sync),
  .auto_resync_en(auto_resync_en),
  .mf_lost       (mf_lost),
  .mf_regain_irq (mf_regain_irq),
  .window_irq    (window_irq),
  .resync_req    (resync_req),
  .crc_check_en  (crc_check_en),
  .ais_req       (ais_req),
  .evt_expire    (evt_expire),
  .evt_good_pair (evt_good_pair),
  .timer_cnt     (timer_cnt)
);

// File: tb/crc4_mf_align_tb_top.sv
`timescale 1ns/1ps
module crc4_mf_align_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0, mf_pat_hit = 1'b0, df_sync = 1'b0;
  logic auto_resync_en = 1'b0, ais_en = 1'b1;
  logic mf_lost, mf_regain_irq, window_irq, crc_check_en, resync_req, ais_req;

  int checks = 0;
  int failures = 0;
  int win_cnt = 0, rsy_cnt = 0, rgn_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  crc4_mf_align dut_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .mf_pat_hit(mf_pat_hit),
    .df_sync(df_sync), .auto_resync_en(auto_resync_en), .ais_en(ais_en),
    .mf_lost(mf_lost), .mf_regain_irq(mf_regain_irq), .window_irq(window_irq),
    .crc_check_en(crc_check_en), .resync_req(resync_req), .ais_req(ais_req)
  );

  // Behavioural reference: mode 0 lost, 1 hunting, 2 one hit held, 3 aligned.
  int m_mode = 0, m_left = 0, m_gap = 0;
  bit m_win = 0, m_rsy = 0, m_rgn = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_gap = 0; m_win = 0; m_rsy = 0; m_rgn = 0;
    end else begin
      bit stb, hit;
      stb = frame_tick; hit = frame_tick && mf_pat_hit;
      m_win = 0; m_rsy = 0; m_rgn = 0;
      if (!df_sync) begin
        m_mode = 0; m_left = 0;
      end else if (m_mode == 0) begin
        m_mode = 1; m_left = 64;
      end else if (m_mode == 1 && stb) begin
        if (hit) begin m_mode = 2; m_left = 48; m_gap = 0; end
        else if (m_left == 1) begin m_win = 1; m_rsy = auto_resync_en; m_left = 64; end
        else m_left = m_left - 1;
      end else if (m_mode == 2 && stb) begin
        m_gap = m_gap + 1;
        if (hit && (m_gap % 16) == 0) begin m_mode = 3; m_rgn = 1; m_left = 0; end
        else if (hit) begin m_gap = 0; m_left = 48; end
        else if (m_left == 1) begin m_win = 1; m_rsy = auto_resync_en; m_mode = 1; m_left = 64; end
        else m_left = m_left - 1;
      end
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 mf_lost",       mf_lost,       m_mode != 3);
      chk("R5 mf_regain_irq", mf_regain_irq, m_rgn);
      chk("R6 window_irq",    window_irq,    m_win);
      chk("R8 resync_req",    resync_req,    m_rsy);
      chk("R2 crc_check_en",  crc_check_en,  m_mode >= 2);
      chk("R9 ais_req",       ais_req,       ais_en && m_mode == 0);
      if (window_irq) win_cnt++;
      if (resync_req) rsy_cnt++;
      if (mf_regain_irq) rgn_cnt++;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(bit hit);
    @(negedge clk);
    frame_tick = 1'b1; mf_pat_hit = hit;
    @(negedge clk);
    frame_tick = 1'b0; mf_pat_hit = 1'b0;
    idle(2);
  endtask

  task automatic frames(int n);
    for (int i = 0; i < n; i++) frame(1'b0);
  endtask

  task automatic df_restart();
    @(negedge clk); df_sync = 1'b0;
    idle(3);
    df_sync = 1'b1;
    idle(2);
  endtask

  initial begin
    idle(3);
    // R1: reset state
    chk("R1 mf_lost", mf_lost, 1'b1);
    chk("R1 crc_check_en", crc_check_en, 1'b0);
    chk("R1 window_irq", window_irq, 1'b0);
    chk("R1 resync_req", resync_req, 1'b0);
    chk("R1 mf_regain_irq", mf_regain_irq, 1'b0);
    chk("R1 ais_req", ais_req, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    df_sync = 1'b1;
    idle(2);
    // R3: hits 16 strobes apart align
    frames(5); frame(1'b1);
    chk("R2 crc after first hit", crc_check_en, 1'b1);
    frames(15);
    chk("R3 not yet aligned", mf_lost, 1'b1);
    frame(1'b1);
    chk("R3 aligned at gap 16", mf_lost, 1'b0);
    chk_int("R5 regain count", rgn_cnt, 1);
    // R10: hits while aligned are ignored
    frame(1'b1); frames(3); frame(1'b1);
    chk("R10 hits ignored when aligned", mf_lost, 1'b0);
    // R9/R10: drop of doubleframe sync
    @(negedge clk); df_sync = 1'b0;
    @(negedge clk);
    chk("R10 lost after drop", mf_lost, 1'b1);
    chk("R10 crc off after drop", crc_check_en, 1'b0);
    chk("R9 ais with enable", ais_req, 1'b1);
    ais_en = 1'b0; idle(1);
    chk("R9 ais masked", ais_req, 1'b0);
    ais_en = 1'b1;
    df_sync = 1'b1; idle(2);
    chk("R9 ais off when df sync", ais_req, 1'b0);
    // R11: hit without strobe
    @(negedge clk); mf_pat_hit = 1'b1;
    @(negedge clk); mf_pat_hit = 1'b0;
    idle(1);
    chk("R11 raw hit ignored", crc_check_en, 1'b0);
    df_restart();
    // R6/R8: 64-strobe windows without resync
    win_cnt = 0; rsy_cnt = 0;
    frames(63);
    chk_int("R6 no irq before 64", win_cnt, 0);
    frames(65);
    chk_int("R6 two windows", win_cnt, 2);
    chk_int("R8 no resync when off", rsy_cnt, 0);
    // R8: with resync enabled
    auto_resync_en = 1'b1;
    df_restart();
    win_cnt = 0;
    frames(64);
    chk_int("R8 resync pulses", rsy_cnt, 1);
    chk_int("R8 with window", win_cnt, 1);
    auto_resync_en = 1'b0;
    // R7: 48-strobe window after a first hit
    df_restart();
    win_cnt = 0;
    frame(1'b1); frames(47);
    chk("R7 crc still on at 47", crc_check_en, 1'b1);
    frames(1);
    chk("R7 crc off after expiry", crc_check_en, 1'b0);
    chk_int("R7 window irq", win_cnt, 1);
    // R4: misaligned hit re-anchors
    df_restart();
    frame(1'b1); frames(10); frame(1'b1);
    chk("R4 misaligned no sync", mf_lost, 1'b1);
    frames(15); frame(1'b1);
    chk("R4 gap 16 from new anchor aligns", mf_lost, 1'b0);
    // R3 boundary: gap 48
    df_restart();
    frame(1'b1); frames(47); frame(1'b1);
    chk("R3 aligned at gap 48", mf_lost, 1'b0);
    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule